// File: doc/BRIEF.md
# Latched Inverting Bidirectional Bus Transceiver

This block links two W-bit tri-state buses, port A and port B. Each transfer direction has its own storage bank and three active-low controls: a direction enable, a load enable and a drive enable. A bank takes in data from its source port while both its direction enable and its load enable are low. When the load enable rises, the bank keeps the last word it took. The bank's far port is driven with the bitwise complement of the stored word only while both that direction's enable and its drive enable are low. The two directions are independent of each other, so one direction can be loading while the other drives.

The block lives in a synchronous clock domain. The load enable acts on clock edges, so the transparent phase copies the source bus into the bank on every rising clock edge. The far port then shows the complemented word one cycle later. Both ports are plain tri-state buses with no handshake. The word on a port is valid whenever the matching drive condition holds, and the bus carries no back-pressure.

Top module: `xcvr_latched_inv`

## Requirements
- R1: After reset both banks hold all zeros, so an enabled output shows all ones (8'hFF at the default width).
- R2: While ab_dir_n and ab_le_n are both low, each rising clock edge loads the value on port A into the A-to-B bank, and B shows its complement after that edge.
- R3: After ab_le_n goes high, the A-to-B bank keeps the word loaded at the last edge where it was low, and B ignores later changes on A.
- R4: Port B is driven only while ab_dir_n and ab_oe_n are both low, and is high-impedance otherwise. The drive enable does not gate loading.
- R5: The word driven onto a port is the bitwise complement of the corresponding bank's stored word.
- R6: While ab_dir_n is high, the A-to-B bank keeps its contents whatever level ab_le_n has, and B stays high-impedance.
- R7: While ba_dir_n and ba_le_n are both low, port B loads into the B-to-A bank on each rising edge. After ba_le_n rises, that bank holds its word against changes on B.
- R8: Port A is driven with the complement of the B-to-A bank only while ba_dir_n and ba_oe_n are both low, and is high-impedance otherwise.
- R9: With the B-to-A bank driving A and the A-to-B bank loading from A and driving B, B settles to the B-to-A bank's stored word (a double complement).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; loads happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears both banks |
| ab_dir_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B load enable, active low |
| ab_oe_n | input | 1 | A-to-B drive enable for port B, active low |
| ba_dir_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A load enable, active low |
| ba_oe_n | input | 1 | B-to-A drive enable for port A, active low |
| a_io | inout | W | Port A bus |
| b_io | inout | W | Port B bus |

## Verification
The A-to-B bank can load from port A in the same cycle that the B-to-A bank drives port A. That makes the block feed its own output back into the other direction. The bench sets up this case by storing a known word in the B-to-A bank, closing that bank's load, and releasing both buses from the bench. It then opens the A-to-B load and drive together. The result is judged correct when B returns the B-to-A bank's word uncomplemented and A holds its complement.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  // Active-low control set for one transfer direction
  typedef struct packed {
    logic dir_n;
    logic le_n;
    logic oe_n;
  } dir_ctl_t;
endpackage

// File: rtl/xcvr_lat_bank.sv
`timescale 1ns/1ps
module xcvr_lat_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_n,
  input  logic         le_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic open_l;

  assign open_l = ~dir_n & ~le_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RST_VAL;
    else if (open_l) q <= d;
  end
endmodule

// File: rtl/xcvr_inv_drv.sv
`timescale 1ns/1ps
module xcvr_inv_drv #(
  parameter int W = 8
) (
  input  logic         dir_n,
  input  logic         oe_n,
  input  logic [W-1:0] q,
  output logic         en,
  output logic [W-1:0] val
);
  assign en = ~dir_n & ~oe_n;

  for (genvar i = 0; i < W; i++) begin : g_inv
    assign val[i] = ~q[i];
  end
endmodule

// File: rtl/xcvr_latched_inv.sv
`timescale 1ns/1ps
module xcvr_latched_inv
  import xcvr_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ab_dir_n,
  input  logic         ab_le_n,
  input  logic         ab_oe_n,
  input  logic         ba_dir_n,
  input  logic         ba_le_n,
  input  logic         ba_oe_n,
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io
);
  dir_ctl_t ab_ctl, ba_ctl;
  logic [W-1:0] ab_store, ba_store;
  logic [W-1:0] ab_val, ba_val;
  logic         ab_en, ba_en;

  assign ab_ctl = '{dir_n: ab_dir_n, le_n: ab_le_n, oe_n: ab_oe_n};
  assign ba_ctl = '{dir_n: ba_dir_n, le_n: ba_le_n, oe_n: ba_oe_n};

  xcvr_lat_bank #(.W(W), .RST_VAL(RST_VAL)) u_ab_bank (
    .clk(clk), .rst_n(rst_n), .dir_n(ab_ctl.dir_n), .le_n(ab_ctl.le_n),
    .d(a_io), .q(ab_store)
  );

  xcvr_lat_bank #(.W(W), .RST_VAL(RST_VAL)) u_ba_bank (
    .clk(clk), .rst_n(rst_n), .dir_n(ba_ctl.dir_n), .le_n(ba_ctl.le_n),
    .d(b_io), .q(ba_store)
  );

  xcvr_inv_drv #(.W(W)) u_ab_drv (
    .dir_n(ab_ctl.dir_n), .oe_n(ab_ctl.oe_n), .q(ab_store),
    .en(ab_en), .val(ab_val)
  );

  xcvr_inv_drv #(.W(W)) u_ba_drv (
    .dir_n(ba_ctl.dir_n), .oe_n(ba_ctl.oe_n), .q(ba_store),
    .en(ba_en), .val(ba_val)
  );

  assign b_io = ab_en ? ab_val : {W{1'bz}};
  assign a_io = ba_en ? ba_val : {W{1'bz}};
endmodule

// File: rtl/xcvr_latched_inv_chk.sv
`timescale 1ns/1ps
module xcvr_latched_inv_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ab_dir_n,
  input logic         ab_le_n,
  input logic         ab_oe_n,
  input logic         ba_dir_n,
  input logic         ba_le_n,
  input logic         ba_oe_n,
  input logic [W-1:0] a_io,
  input logic [W-1:0] b_io,
  input logic [W-1:0] ab_store,
  input logic [W-1:0] ba_store
);
  // R2
  ab_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_dir_n && !ab_le_n) |=> (ab_store == $past(a_io)));
  // R3
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le_n |=> $stable(ab_store));
  // R6
  ab_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_dir_n |=> $stable(ab_store));
  // R5
  b_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_dir_n && !ab_oe_n) |-> (b_io == ~ab_store));
  // R7
  ba_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_dir_n && !ba_le_n) |=> (ba_store == $past(b_io)));
  // R7
  ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_le_n || ba_dir_n) |=> $stable(ba_store));
  // R8
  a_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_dir_n && !ba_oe_n) |-> (a_io == ~ba_store));
endmodule

bind xcvr_latched_inv xcvr_latched_inv_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ab_dir_n(ab_dir_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
  .ba_dir_n(ba_dir_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
  .a_io(a_io), .b_io(b_io), .ab_store(ab_store), .ba_store(ba_store)
);

// File: tb/tb_xcvr_latched_inv.sv
`timescale 1ns/1ps
module tb_xcvr_latched_inv;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ab_dir_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
  logic ba_dir_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
  logic [W-1:0] a_drv = '0, b_drv = '0;
  logic a_en = 1'b0, b_en = 1'b0;
  wire  [W-1:0] a_bus, b_bus;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign a_bus = a_en ? a_drv : {W{1'bz}};
  assign b_bus = b_en ? b_drv : {W{1'bz}};

  always #2.5 clk = ~clk;

  xcvr_latched_inv #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .ab_dir_n(ab_dir_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_dir_n(ba_dir_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_io(a_bus), .b_io(b_bus)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bus undriven by the design: the bench's own word must come back unchanged
  task automatic chk_b_free(input string tag);
    b_en = 1'b1;
    b_drv = 8'h00; #1; chk(tag, b_bus, 8'h00);
    b_drv = 8'hFF; #1; chk(tag, b_bus, 8'hFF);
    b_en = 1'b0;
  endtask

  task automatic chk_a_free(input string tag);
    a_en = 1'b1;
    a_drv = 8'h00; #1; chk(tag, a_bus, 8'h00);
    a_drv = 8'hFF; #1; chk(tag, a_bus, 8'hFF);
    a_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    ab_dir_n = 1'b0; ab_oe_n = 1'b0;
    @(negedge clk);
    chk("R1 B after reset", b_bus, 8'hFF);
    ab_dir_n = 1'b1; ab_oe_n = 1'b1;
    ba_dir_n = 1'b0; ba_oe_n = 1'b0;
    @(negedge clk);
    chk("R1 A after reset", a_bus, 8'hFF);
    ba_dir_n = 1'b1; ba_oe_n = 1'b1;
  endtask

  task automatic t_ab_transparent();
    a_en = 1'b1;
    ab_dir_n = 1'b0; ab_le_n = 1'b0; ab_oe_n = 1'b0;
    a_drv = 8'h3C; @(negedge clk);
    chk("R2 R5 B follows A 3C", b_bus, 8'hC3);
    a_drv = 8'hA5; @(negedge clk);
    chk("R2 R5 B follows A A5", b_bus, 8'h5A);
    a_drv = 8'h00; @(negedge clk);
    chk("R2 R5 B follows A 00", b_bus, 8'hFF);
  endtask

  task automatic t_ab_capture();
    a_drv = 8'h81; @(negedge clk);
    ab_le_n = 1'b1; @(negedge clk);
    chk("R3 captured word", b_bus, 8'h7E);
    a_drv = 8'hFF; @(negedge clk);
    chk("R3 A change ignored", b_bus, 8'h7E);
    a_drv = 8'h18; @(negedge clk);
    chk("R3 A change ignored again", b_bus, 8'h7E);
  endtask

  task automatic t_ab_oe();
    ab_oe_n = 1'b1; @(negedge clk);
    chk_b_free("R4 B free with oe high");
    ab_le_n = 1'b0; a_drv = 8'h42; @(negedge clk);
    ab_le_n = 1'b1; @(negedge clk);
    chk_b_free("R4 B free after load");
    ab_oe_n = 1'b0; @(negedge clk);
    chk("R4 load while oe high", b_bus, 8'hBD);
  endtask

  task automatic t_ab_dir_off();
    ab_dir_n = 1'b1; ab_le_n = 1'b0; a_drv = 8'h99;
    @(negedge clk); @(negedge clk);
    chk_b_free("R6 B free with dir high");
    ab_dir_n = 1'b0; ab_le_n = 1'b1; @(negedge clk);
    chk("R6 bank held while dir high", b_bus, 8'hBD);
    ab_dir_n = 1'b1; ab_oe_n = 1'b1; a_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_ba();
    b_en = 1'b1;
    ba_dir_n = 1'b0; ba_le_n = 1'b0; ba_oe_n = 1'b0;
    b_drv = 8'h12; @(negedge clk);
    chk("R7 R8 A follows B 12", a_bus, 8'hED);
    b_drv = 8'h34; @(negedge clk);
    chk("R7 R8 A follows B 34", a_bus, 8'hCB);
    ba_le_n = 1'b1; b_drv = 8'h56; @(negedge clk);
    chk("R7 B change ignored", a_bus, 8'hCB);
    ba_oe_n = 1'b1; @(negedge clk);
    chk_a_free("R8 A free with oe high");
    ba_dir_n = 1'b1; ba_oe_n = 1'b0; @(negedge clk);
    chk_a_free("R8 A free with dir high");
    ba_dir_n = 1'b0; b_drv = 8'hF0; ba_le_n = 1'b0; @(negedge clk);
    ba_le_n = 1'b1; @(negedge clk);
    chk("R8 A shows stored complement", a_bus, 8'h0F);
  endtask

  task automatic t_loop();
    b_en = 1'b0;
    ab_dir_n = 1'b0; ab_le_n = 1'b0; ab_oe_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 A driven by B-to-A bank", a_bus, 8'h0F);
    chk("R9 B returns B-to-A word", b_bus, 8'hF0);
    ab_le_n = 1'b1; ab_oe_n = 1'b1; ab_dir_n = 1'b1;
    ba_oe_n = 1'b1; ba_dir_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ab_transparent();
    t_ab_capture();
    t_ab_oe();
    t_ab_dir_off();
    t_ba();
    t_loop();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule